// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, for a bank of interrupt request lines (eight by default), whether the processor interrupt should be raised and which request level should win. It has three pieces of state. The first is a mask register with one bit per line. The second is a pointer naming the level that currently has the lowest priority. The third is a flag that makes the priority rotate each time an interrupt is serviced with automatic end-of-interrupt. Outside logic owns the pending-request and in-service vectors and feeds them in. This block only arbitrates them and keeps its own pointer, mask and flag up to date.

Software reaches the block through two write strobes. One loads the mask. The other carries three command flags: rotate (`cmd_rot_i`), select (`cmd_sel_i`) and end-of-interrupt (`cmd_eoi_i`), plus a level field. Together they can place the pointer directly, rotate it to the highest in-service level, or switch the rotate-on-auto-EOI flag on or off. The service logic pulses a separate strobe each time an interrupt is retired automatically, and that strobe moves the pointer when the flag is set.

A special mask mode input changes how in-service levels block requests. When it is active, a level whose mask bit is set stops holding off other requests. Software can then open lower-priority lines while a handler is running. All pins are plain control and status signals with no flow control. Every input is sampled on each rising clock edge, and the outputs are valid in every cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the pointer reads 7 (line 0 has the highest priority), every mask bit is clear and the rotate-on-auto-EOI flag is off.
- R2: Priority is ranked by the distance (level − pointer − 1) mod 8, and the smallest distance is the highest priority. When `irq_o` is 1, `win_lvl_o` is the level of the highest-priority eligible request. When `irq_o` is 0, `win_lvl_o` is 0.
- R3: A `mask_we_i` pulse loads `mask_data_i` into the mask at the next edge. Mask bit k removes request line k from arbitration and has no effect on any other line.
- R4: When special mask mode is off, every set in-service bit blocks requests. An eligible request raises `irq_o` only if its priority is strictly higher than that of the highest-priority in-service level.
- R5: When special mask mode is on, an in-service bit whose mask bit is set blocks nothing. In-service bits that are unmasked still block as in R4.
- R6: A command with rot=1 and sel=1 loads the command level into the pointer at the next edge, whatever the value of eoi. The level that follows it becomes the highest priority. The flag is left unchanged.
- R7: A command with rot=1, sel=0 and eoi=1 moves the pointer to the highest-priority blocking in-service level, with blocking taken as defined in R4 and R5. If no in-service bit blocks, the pointer is left unchanged.
- R8: A command with rot=1, sel=0 and eoi=0 sets the rotate-on-auto-EOI flag. A command with rot=0, sel=0 and eoi=0 clears it.
- R9: An `aeoi_ev_i` pulse moves the pointer to `aeoi_lvl_i` when the flag is set. When the flag is clear, the pulse has no effect.
- R10: If an auto-EOI pulse and a pointer-writing command fall in the same cycle, the command's pointer value wins. The auto-EOI pulse is judged by the flag value from before that cycle's command.
- R11: Commands with rot=0 and either sel=1 or eoi=1 change neither the pointer nor the flag.
- R12: With the flag set, all lines requesting and each winner then serviced by an auto-EOI pulse, the eight lines win in turn and each wins once in eight services.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Pending request vector, one bit per line |
| insvc_i | input | 8 | In-service vector, one bit per line |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | Mask value to load |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_rot_i | input | 1 | Command rotate flag |
| cmd_sel_i | input | 1 | Command select flag (level field is used) |
| cmd_eoi_i | input | 1 | Command end-of-interrupt flag |
| cmd_lvl_i | input | 3 | Command level field |
| smm_en_i | input | 1 | Special mask mode enable |
| aeoi_ev_i | input | 1 | Automatic end-of-interrupt event strobe |
| aeoi_lvl_i | input | 3 | Level serviced by the auto-EOI event |
| irq_o | output | 1 | Interrupt request to the processor |
| win_lvl_o | output | 3 | Winning request level |
| ptr_o | output | 3 | Current lowest-priority pointer |

## Verification
Two functions can fall in the same cycle: a command that writes the pointer, and an auto-EOI rotation event. The bench sets both strobes on one edge in three variants. In the first, a set-priority command meets an event. In the second, a flag-off command meets an event. In the third, a rotate-on-EOI command that finds no in-service level meets an event. In each variant `ptr_o` after the edge must show the command's level if the command wrote the pointer, and otherwise the event's level as governed by the flag value from before the edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_PRIO,
    OP_ROT_EOI,
    OP_FLAG_ON,
    OP_FLAG_OFF
  } prio_op_e;

  function automatic prio_op_e decode_op(input logic rot, input logic sel, input logic eoi);
    prio_op_e op;
    if (rot && sel)             op = OP_SET_PRIO;
    else if (rot && eoi)        op = OP_ROT_EOI;
    else if (rot)               op = OP_FLAG_ON;
    else if (!sel && !eoi)      op = OP_FLAG_OFF;
    else                        op = OP_NONE;
    return op;
  endfunction

endpackage

// File: rtl/irq_prio_rotate.sv
// Reorders a per-line vector so that bit 0 is the highest priority line.
module irq_prio_rotate #(
  parameter int N_LINES = 8,
  localparam int LVL_W = $clog2(N_LINES)
) (
  input  logic [LVL_W-1:0]   ptr_i,
  input  logic [N_LINES-1:0] vec_i,
  output logic [N_LINES-1:0] vec_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_pos
    localparam logic [LVL_W-1:0] OFS = LVL_W'(i + 1);
    logic [LVL_W-1:0] src;
    assign src = ptr_i + OFS;
    assign vec_o[i] = vec_i[src];
  end
endmodule

// File: rtl/irq_prio_first.sv
// Finds the lowest set index of a vector.
module irq_prio_first #(
  parameter int N_LINES = 8,
  localparam int LVL_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  output logic               found_o,
  output logic [LVL_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LVL_W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/irq_prio_state.sv
// Mask register, lowest-priority pointer and rotate-on-auto-EOI flag.
module irq_prio_state
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LVL_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_data_i,
  input  logic               cmd_we_i,
  input  logic               cmd_rot_i,
  input  logic               cmd_sel_i,
  input  logic               cmd_eoi_i,
  input  logic [LVL_W-1:0]   cmd_lvl_i,
  input  logic               aeoi_ev_i,
  input  logic [LVL_W-1:0]   aeoi_lvl_i,
  input  logic               blk_found_i,
  input  logic [LVL_W-1:0]   blk_lvl_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [LVL_W-1:0]   ptr_o,
  output logic               rot_flag_o
);
  localparam logic [LVL_W-1:0] PTR_RST = LVL_W'(N_LINES - 1);

  logic [N_LINES-1:0] mask_q;
  logic [LVL_W-1:0]   ptr_q, ptr_d;
  logic               flag_q, flag_d;
  prio_op_e           op;

  assign op = decode_op(cmd_rot_i, cmd_sel_i, cmd_eoi_i);

  always_comb begin
    ptr_d  = ptr_q;
    flag_d = flag_q;
    // the auto-EOI event sees the flag from before this cycle's command
    if (aeoi_ev_i && flag_q) ptr_d = aeoi_lvl_i;
    if (cmd_we_i) begin
      unique case (op)
        OP_SET_PRIO: ptr_d = cmd_lvl_i;
        OP_ROT_EOI:  if (blk_found_i) ptr_d = blk_lvl_i;
        OP_FLAG_ON:  flag_d = 1'b1;
        OP_FLAG_OFF: flag_d = 1'b0;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= PTR_RST;
      flag_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i;
      ptr_q  <= ptr_d;
      flag_q <= flag_d;
    end
  end

  assign mask_o     = mask_q;
  assign ptr_o      = ptr_q;
  assign rot_flag_o = flag_q;

  assert_set_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_rot_i && cmd_sel_i) |=> (ptr_o == $past(cmd_lvl_i)) && $stable(flag_q));

  assert_flag_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && cmd_rot_i && !cmd_sel_i && !cmd_eoi_i) |=> flag_q);

  assert_flag_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !cmd_rot_i && !cmd_sel_i && !cmd_eoi_i) |=> !flag_q);

  assert_aeoi_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi_ev_i && flag_q && !(cmd_we_i && cmd_rot_i)) |=> (ptr_o == $past(aeoi_lvl_i)));

  assert_aeoi_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi_ev_i && !flag_q && !cmd_we_i) |=> $stable(ptr_o));

  assert_cmd_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_i && !cmd_rot_i && (cmd_sel_i || cmd_eoi_i) && !aeoi_ev_i)
      |=> $stable(ptr_o) && $stable(flag_q));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_data_i)));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LVL_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] insvc_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_data_i,
  input  logic               cmd_we_i,
  input  logic               cmd_rot_i,
  input  logic               cmd_sel_i,
  input  logic               cmd_eoi_i,
  input  logic [LVL_W-1:0]   cmd_lvl_i,
  input  logic               smm_en_i,
  input  logic               aeoi_ev_i,
  input  logic [LVL_W-1:0]   aeoi_lvl_i,
  output logic               irq_o,
  output logic [LVL_W-1:0]   win_lvl_o,
  output logic [LVL_W-1:0]   ptr_o
);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic [N_LINES-1:0] mask_q;
  logic [LVL_W-1:0]   ptr_q;
  logic               rot_flag;

  logic [N_LINES-1:0] req_eff, blk_eff;
  logic [N_LINES-1:0] req_rot, blk_rot;
  logic               req_found, blk_found;
  logic [LVL_W-1:0]   req_idx, blk_idx;
  logic [LVL_W-1:0]   blk_lvl;

  // in special mask mode a masked in-service level no longer holds others off
  assign req_eff = req_i & ~mask_q;
  assign blk_eff = smm_en_i ? (insvc_i & ~mask_q) : insvc_i;

  irq_prio_rotate #(.N_LINES(N_LINES)) u_rot_req (
    .ptr_i(ptr_q), .vec_i(req_eff), .vec_o(req_rot)
  );
  irq_prio_rotate #(.N_LINES(N_LINES)) u_rot_blk (
    .ptr_i(ptr_q), .vec_i(blk_eff), .vec_o(blk_rot)
  );

  irq_prio_first #(.N_LINES(N_LINES)) u_first_req (
    .vec_i(req_rot), .found_o(req_found), .idx_o(req_idx)
  );
  irq_prio_first #(.N_LINES(N_LINES)) u_first_blk (
    .vec_i(blk_rot), .found_o(blk_found), .idx_o(blk_idx)
  );

  assign blk_lvl = ptr_q + blk_idx + ONE;

  irq_prio_state #(.N_LINES(N_LINES)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we_i   (mask_we_i),
    .mask_data_i (mask_data_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_rot_i   (cmd_rot_i),
    .cmd_sel_i   (cmd_sel_i),
    .cmd_eoi_i   (cmd_eoi_i),
    .cmd_lvl_i   (cmd_lvl_i),
    .aeoi_ev_i   (aeoi_ev_i),
    .aeoi_lvl_i  (aeoi_lvl_i),
    .blk_found_i (blk_found),
    .blk_lvl_i   (blk_lvl),
    .mask_o      (mask_q),
    .ptr_o       (ptr_q),
    .rot_flag_o  (rot_flag)
  );

  assign irq_o     = req_found && (!blk_found || (req_idx < blk_idx));
  assign win_lvl_o = irq_o ? (ptr_q + req_idx + ONE) : '0;
  assign ptr_o     = ptr_q;

  assert_win_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_i[win_lvl_o] && !mask_q[win_lvl_o]));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (win_lvl_o == '0));

  assert_nested_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !smm_en_i) |-> !insvc_i[win_lvl_o]);

  assert_no_irq_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i & ~mask_q) == '0) |-> !irq_o);
endmodule

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0, insvc_i = '0, mask_data_i = '0;
  logic       mask_we_i = 1'b0, cmd_we_i = 1'b0, cmd_rot_i = 1'b0;
  logic       cmd_sel_i = 1'b0, cmd_eoi_i = 1'b0, smm_en_i = 1'b0, aeoi_ev_i = 1'b0;
  logic [2:0] cmd_lvl_i = '0, aeoi_lvl_i = '0;
  logic       irq_o;
  logic [2:0] win_lvl_o, ptr_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  irq_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .insvc_i(insvc_i),
    .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
    .cmd_we_i(cmd_we_i), .cmd_rot_i(cmd_rot_i), .cmd_sel_i(cmd_sel_i),
    .cmd_eoi_i(cmd_eoi_i), .cmd_lvl_i(cmd_lvl_i), .smm_en_i(smm_en_i),
    .aeoi_ev_i(aeoi_ev_i), .aeoi_lvl_i(aeoi_lvl_i),
    .irq_o(irq_o), .win_lvl_o(win_lvl_o), .ptr_o(ptr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected {irq, level} as irq*16 + level, from the distance rule
  function automatic int model(input int rq, input int is, input int mk,
                               input int ptr, input bit smm);
    int best_r = 99, best_b = 99, lvl_r = 0;
    int blk = smm ? (is & ~mk) : is;
    for (int l = 0; l < 8; l++) begin
      int d = (l - ptr - 1 + 16) % 8;
      if (((rq & ~mk) >> l) & 1) if (d < best_r) begin best_r = d; lvl_r = l; end
      if ((blk >> l) & 1) if (d < best_b) best_b = d;
    end
    if (best_r != 99 && best_r < best_b) return 16 + lvl_r;
    return 0;
  endfunction

  task automatic cmd(input bit r, input bit s, input bit e, input int lvl,
                     input bit ev, input int evl);
    @(negedge clk);
    cmd_we_i = 1'b1; cmd_rot_i = r; cmd_sel_i = s; cmd_eoi_i = e; cmd_lvl_i = 3'(lvl);
    aeoi_ev_i = ev; aeoi_lvl_i = 3'(evl);
    @(negedge clk);
    cmd_we_i = 1'b0; aeoi_ev_i = 1'b0;
  endtask

  task automatic aeoi(input int evl);
    @(negedge clk);
    aeoi_ev_i = 1'b1; aeoi_lvl_i = 3'(evl);
    @(negedge clk);
    aeoi_ev_i = 1'b0;
  endtask

  task automatic set_mask(input int m);
    @(negedge clk);
    mask_we_i = 1'b1; mask_data_i = 8'(m);
    @(negedge clk);
    mask_we_i = 1'b0;
  endtask

  task automatic run_all();
    int mval;
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pointer after reset", int'(ptr_o), 7);
    req_i = 8'hFF; insvc_i = 8'h00; #1;
    chk("R1 mask clear, line 0 wins", int'({irq_o, 1'b0, win_lvl_o}), 16);
    aeoi(4);
    chk("R1 flag clear, event ignored", int'(ptr_o), 7);

    // R6: set priority
    cmd(1, 1, 0, 5, 0, 0);
    chk("R6 pointer set to 5", int'(ptr_o), 5);
    #1 chk("R6 line 6 highest", int'({irq_o, 1'b0, win_lvl_o}), 16 + 6);
    cmd(1, 1, 1, 2, 0, 0);
    chk("R6 set with eoi flag", int'(ptr_o), 2);
    aeoi(4);
    chk("R6 flag untouched", int'(ptr_o), 2);

    // R8 / R9: flag control and auto-EOI rotation
    cmd(1, 0, 0, 0, 0, 0);
    aeoi(4);
    chk("R9 event moves pointer", int'(ptr_o), 4);
    cmd(0, 0, 0, 0, 0, 0);
    aeoi(1);
    chk("R8 flag off, event ignored", int'(ptr_o), 4);

    // R11: ignored codes
    cmd(0, 1, 0, 6, 0, 0);
    chk("R11 rot0 sel1", int'(ptr_o), 4);
    cmd(0, 1, 1, 6, 0, 0);
    chk("R11 rot0 sel1 eoi1", int'(ptr_o), 4);
    insvc_i = 8'h24;
    cmd(0, 0, 1, 3, 0, 0);
    chk("R11 plain eoi", int'(ptr_o), 4);
    aeoi(1);
    chk("R11 flag stays off", int'(ptr_o), 4);
    cmd(1, 0, 0, 0, 0, 0);
    cmd(0, 0, 1, 0, 0, 0);
    aeoi(2);
    chk("R11 flag stays on", int'(ptr_o), 2);
    cmd(0, 0, 0, 0, 0, 0);

    // R7: rotate on non-specific EOI
    cmd(1, 1, 0, 7, 0, 0);
    insvc_i = 8'h24; smm_en_i = 1'b0;
    cmd(1, 0, 1, 0, 0, 0);
    chk("R7 highest in-service 2", int'(ptr_o), 2);
    cmd(1, 1, 0, 7, 0, 0);
    set_mask(8'h04);
    cmd(1, 0, 1, 0, 0, 0);
    chk("R7 mask ignored outside special mode", int'(ptr_o), 2);
    cmd(1, 1, 0, 7, 0, 0);
    smm_en_i = 1'b1;
    cmd(1, 0, 1, 0, 0, 0);
    chk("R7 special mode skips masked level", int'(ptr_o), 5);
    smm_en_i = 1'b0;
    set_mask(0);
    cmd(1, 1, 0, 3, 0, 0);
    insvc_i = 8'h00;
    cmd(1, 0, 1, 0, 0, 0);
    chk("R7 nothing in service", int'(ptr_o), 3);

    // R10: collisions
    cmd(1, 0, 0, 0, 0, 0);
    cmd(1, 1, 0, 4, 1, 1);
    chk("R10 set beats event", int'(ptr_o), 4);
    cmd(1, 0, 1, 0, 1, 5);
    chk("R10 empty rotate lets event through", int'(ptr_o), 5);
    cmd(0, 0, 0, 0, 1, 6);
    chk("R10 event uses old flag", int'(ptr_o), 6);
    aeoi(3);
    chk("R10 flag now off", int'(ptr_o), 6);

    // R12: round robin over all lines
    cmd(1, 0, 0, 0, 0, 0);
    cmd(1, 1, 0, 7, 0, 0);
    req_i = 8'hFF; insvc_i = 8'h00;
    for (int k = 0; k < 8; k++) begin
      #1 chk("R12 turn order", int'({irq_o, 1'b0, win_lvl_o}), 16 + k);
      aeoi(int'(win_lvl_o));
    end
    #1 chk("R12 wraps to line 0", int'({irq_o, 1'b0, win_lvl_o}), 16);
    cmd(0, 0, 0, 0, 0, 0);

    // R2..R5: sweep over pointer, mask, mode, requests, in-service
    for (int p = 0; p < 8; p++) begin
      cmd(1, 1, 0, p, 0, 0);
      for (int mi = 0; mi < 2; mi++) begin
        mval = (mi == 0) ? 0 : 8'hA5;
        set_mask(mval);
        for (int s = 0; s < 2; s++) begin
          for (int r = 0; r < 256; r++) begin
            for (int k = 0; k < 10; k++) begin
              int isv = (k == 0) ? 0 : (k == 9) ? 8'h81 : (1 << (k - 1));
              string tag;
              @(negedge clk);
              req_i = 8'(r); insvc_i = 8'(isv); smm_en_i = s[0];
              #1;
              if (s != 0) tag = "R5 sweep";
              else if (isv != 0) tag = "R4 sweep";
              else if (mval != 0) tag = "R3 sweep";
              else tag = "R2 sweep";
              chk(tag, int'({irq_o, 1'b0, win_lvl_o}), model(r, isv, mval, p, s[0]));
            end
          end
        end
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        wait (cycles >= 190000);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) chk("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule